// File: doc/BRIEF.md
# Per-Processor Local Interrupt Register Bank

This block keeps one small register group for each processor in a multi-processor system and turns the compare-match event of each processor into an interrupt line. Every bus access carries the index of the processor that issues it. The access also selects one of two windows. The self window reaches the requester's own group. The indirect window reaches the group whose index is held in the requester's other-address register. With this, one processor can set up the local state of another processor through the same register layout it uses for itself.

Each group holds a six-bit local mask, a compare pending flag, a compare routing register (an enable flag and a line number), an other-address index and a 32-bit compare value. The mask is never written directly. Software changes it through a set register and a clear register. An external counter comparator reads the compare values from the block and returns one match strobe per processor. The block latches that strobe as a pending flag and drives the routed interrupt line while the flag is unmasked and routing is enabled.

Register index encoding on `bus_reg`:
- 0: control
- 1: pending (compare flag at bit 1)
- 2: mask (bits 5:0)
- 3: mask-set
- 4: mask-clear
- 5: routing (enable at bit 31, line at bits 5:0)
- 6: other-address
- 7: identity
- 8: compare value
- 9: compare high

Top module: `local_irq_regs`

## Requirements
- R1: With `bus_win`=0 an access targets the group of `bus_proc`, and a read of index 7 (identity) returns `bus_proc`.
- R2: With `bus_win`=1 an access targets the group named by the other-address register (index 6) of `bus_proc`, and identity returns that group's index.
- R3: A write to index 6 whose data is not below NPROC leaves the other-address register unchanged.
- R4: A write to index 3 ORs data bits 5:0 into the mask. A write to index 4 clears every mask bit whose data bit is 1. Index 2 reads the mask in bits 5:0. Other groups are untouched.
- R5: A one-cycle `cmp_hit[p]` sets group p's compare pending flag, which reads as 0x2 at index 1 from the next cycle.
- R6: `cpu_irq[p*6+L]` is 1 exactly when group p's pending flag, mask bit 1 and routing enable bit 31 are all 1 and its routing line is L. All other lines of p are 0.
- R7: A write to index 8 stores the compare value, which reads back and appears on `cmp_value[p*32 +: 32]`. It also clears the pending flag, even when `cmp_hit[p]` is high in the same cycle.
- R8: A write to index 5 whose bits 5:0 exceed MAX_PIN (5) is discarded. Otherwise only bit 31 and bits 5:0 are kept.
- R9: Index 9 always reads 0. Index 0 reads 0, and writes to it change nothing.
- R10: After reset, control, pending and other-address read 0, the mask reads 0x32, routing reads 0x8000_0000, the compare value is 0xFFFF_FFFF and all `cpu_irq` lines are low.
- R11: Reads return data combinationally while `bus_rd` is 1. Reads give 0 while `bus_rd` is 0 or at indices 10 to 15. Writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, committed at the rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_win | input | 1 | 0 selects the self window, 1 selects the indirect window |
| bus_proc | input | PW | Index of the requesting processor |
| bus_reg | input | 4 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| cmp_hit | input | NPROC | Compare-match strobe per processor |
| cmp_value | output | NPROC*32 | Compare value of each group, for the comparator |
| cpu_irq | output | NPROC*(MAX_PIN+1) | Interrupt lines, MAX_PIN+1 per processor |

## Verification
Several behaviours are checked by assertions on every cycle:
- a rejected other-address or routing write leaves the register unchanged;
- a match strobe always leaves the pending flag set unless a compare write targets that group;
- a compare write always clears the flag;
- at most one line per processor is ever high;
- the compare high index reads zero.

Other behaviours can only be shown by the bench's scenarios:
- the window indirection;
- the set/clear arithmetic on the mask;
- the exact line that rises for a given routing;
- the masking and unmasking of a pending flag;
- the reset contents.

// File: rtl/local_irq_regs.sv
module local_irq_regs #(
  parameter int NPROC    = 4,
  parameter int MAX_PIN  = 5,
  parameter int CMP_BIT  = 1,
  parameter logic [5:0] MASK_RST = 6'h32,
  parameter logic [5:0] MASK_WR  = 6'h3F,
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int NL = MAX_PIN + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic                  bus_win,
  input  logic [PW-1:0]         bus_proc,
  input  logic [3:0]            bus_reg,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NPROC-1:0]      cmp_hit,
  output logic [NPROC*32-1:0]   cmp_value,
  output logic [NPROC*NL-1:0]   cpu_irq
);

  localparam logic [3:0] IX_CTRL  = 4'd0;
  localparam logic [3:0] IX_PEND  = 4'd1;
  localparam logic [3:0] IX_MASK  = 4'd2;
  localparam logic [3:0] IX_SET   = 4'd3;
  localparam logic [3:0] IX_CLR   = 4'd4;
  localparam logic [3:0] IX_ROUTE = 4'd5;
  localparam logic [3:0] IX_OTHER = 4'd6;
  localparam logic [3:0] IX_IDENT = 4'd7;
  localparam logic [3:0] IX_CMP   = 4'd8;
  localparam logic [3:0] IX_CMPHI = 4'd9;

  logic [5:0]    mask_q  [NPROC];
  logic          pend_q  [NPROC];
  logic          ren_q   [NPROC];
  logic [5:0]    rpin_q  [NPROC];
  logic [PW-1:0] other_q [NPROC];
  logic [31:0]   cmp_q   [NPROC];
  logic [PW-1:0] tgt;

  assign tgt = bus_win ? other_q[bus_proc] : bus_proc;

  wire route_ok = bus_wdata[5:0] <= 6'(MAX_PIN);
  wire other_ok = bus_wdata < 32'(NPROC);

  for (genvar p = 0; p < NPROC; p++) begin : g_grp
    wire hit_me = bus_wr && (tgt == PW'(p));
    wire wr_cmp = hit_me && (bus_reg == IX_CMP);
    wire lvl    = pend_q[p] && mask_q[p][CMP_BIT] && ren_q[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[p]  <= MASK_RST;
        pend_q[p]  <= 1'b0;
        ren_q[p]   <= 1'b1;
        rpin_q[p]  <= 6'd0;
        other_q[p] <= '0;
        cmp_q[p]   <= 32'hFFFF_FFFF;
      end else begin
        if (wr_cmp)          pend_q[p] <= 1'b0;
        else if (cmp_hit[p]) pend_q[p] <= 1'b1;
        if (hit_me) begin
          case (bus_reg)
            IX_SET:   mask_q[p] <= mask_q[p] | (bus_wdata[5:0] & MASK_WR);
            IX_CLR:   mask_q[p] <= mask_q[p] & ~(bus_wdata[5:0] & MASK_WR);
            IX_ROUTE: if (route_ok) begin
                        ren_q[p]  <= bus_wdata[31];
                        rpin_q[p] <= bus_wdata[5:0];
                      end
            IX_OTHER: if (other_ok) other_q[p] <= bus_wdata[PW-1:0];
            IX_CMP:   cmp_q[p] <= bus_wdata;
            default:  ;
          endcase
        end
      end
    end

    assign cmp_value[p*32 +: 32] = cmp_q[p];

    for (genvar l = 0; l < NL; l++) begin : g_line
      assign cpu_irq[p*NL + l] = lvl && (rpin_q[p] == 6'(l));
    end

    AST_OTHER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_me && bus_reg == IX_OTHER && !other_ok) |=> $stable(other_q[p])); // R3
    AST_ROUTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_me && bus_reg == IX_ROUTE && !route_ok) |=> ($stable(rpin_q[p]) && $stable(ren_q[p]))); // R8
    AST_HIT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_hit[p] && !wr_cmp) |=> pend_q[p]); // R5
    AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmp |=> !pend_q[p]); // R7
    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cpu_irq[p*NL +: NL])); // R6
  end

  always_comb begin
    bus_rdata = 32'd0;
    if (bus_rd) begin
      case (bus_reg)
        IX_PEND:  bus_rdata = 32'(pend_q[tgt]) << CMP_BIT;
        IX_MASK:  bus_rdata = {26'd0, mask_q[tgt]};
        IX_ROUTE: bus_rdata = {ren_q[tgt], 25'd0, rpin_q[tgt]};
        IX_OTHER: bus_rdata = 32'(other_q[tgt]);
        IX_IDENT: bus_rdata = 32'(tgt);
        IX_CMP:   bus_rdata = cmp_q[tgt];
        default:  bus_rdata = 32'd0;
      endcase
    end
  end

  AST_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_reg == IX_CMPHI || bus_reg == IX_CTRL)) |-> bus_rdata == 32'd0); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 32'd0); // R11

endmodule

// File: tb/local_irq_regs_test.sv
module local_irq_regs_test;
  localparam int CLK_NS = 10;
  localparam int NP = 4;
  localparam int NL = 6;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, bus_win = 0;
  logic [1:0] bus_proc = 0;
  logic [3:0] bus_reg = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] cmp_hit = 0;
  logic [NP*32-1:0] cmp_value;
  logic [NP*NL-1:0] cpu_irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  local_irq_regs uut (.clk, .rst_n, .bus_wr, .bus_rd, .bus_win, .bus_proc,
    .bus_reg, .bus_wdata, .bus_rdata, .cmp_hit, .cmp_value, .cpu_irq);

  typedef struct packed {
    logic wr; logic win; logic [1:0] proc; logic [3:0] rg;
    logic [31:0] d; logic [31:0] exp; logic [7:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{0,0,2'd0,4'd7, 32'h0,        32'h0,        8'd1},  // R1 identity p0
    '{0,0,2'd2,4'd7, 32'h0,        32'h2,        8'd1},  // R1 identity p2
    '{1,0,2'd0,4'd6, 32'h3,        32'h0,        8'd2},
    '{0,1,2'd0,4'd7, 32'h0,        32'h3,        8'd2},  // R2 indirect identity
    '{1,0,2'd0,4'd6, 32'h4,        32'h0,        8'd3},
    '{0,0,2'd0,4'd6, 32'h0,        32'h3,        8'd3},  // R3 out-of-range ignored
    '{1,1,2'd0,4'd3, 32'hFFFFFF01, 32'h0,        8'd4},
    '{0,0,2'd3,4'd2, 32'h0,        32'h33,       8'd4},  // R4 set via indirect
    '{1,0,2'd3,4'd4, 32'h12,       32'h0,        8'd4},
    '{0,0,2'd3,4'd2, 32'h0,        32'h21,       8'd4},  // R4 clear
    '{0,0,2'd1,4'd2, 32'h0,        32'h32,       8'd4},  // R4 others untouched
    '{1,0,2'd1,4'd5, 32'h80000006, 32'h0,        8'd8},
    '{0,0,2'd1,4'd5, 32'h0,        32'h80000000, 8'd8},  // R8 discarded
    '{1,0,2'd1,4'd5, 32'hFFFFFF03, 32'h0,        8'd8},
    '{0,0,2'd1,4'd5, 32'h0,        32'h80000003, 8'd8},  // R8 kept bits
    '{1,0,2'd1,4'd0, 32'hFFFFFFFF, 32'h0,        8'd9},
    '{0,0,2'd1,4'd0, 32'h0,        32'h0,        8'd9},  // R9 control
    '{0,0,2'd1,4'd9, 32'h0,        32'h0,        8'd9},  // R9 compare high
    '{1,0,2'd2,4'd8, 32'h1234,     32'h0,        8'd7},
    '{0,0,2'd2,4'd8, 32'h0,        32'h1234,     8'd7},  // R7 readback
    '{0,0,2'd0,4'd12,32'h0,        32'h0,        8'd11}  // R11 unused index
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic win, input logic [1:0] p, input logic [3:0] rg, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_rd = 0; bus_win = win; bus_proc = p; bus_reg = rg; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic win, input logic [1:0] p, input logic [3:0] rg, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_wr = 0; bus_rd = 1; bus_win = win; bus_proc = p; bus_reg = rg;
    #1 check(bus_rdata === exp, tag, bus_rdata, exp);
    bus_rd = 0;
  endtask

  task automatic pulse(input int p);
    @(negedge clk); cmp_hit[p] = 1;
    @(negedge clk); cmp_hit[p] = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    #(CLK_NS * 3) rst_n = 1;
    // R10 reset contents
    #1 check(cpu_irq === '0, "R10 irq", 32'(cpu_irq), 0);
    check(cmp_value === {NP{32'hFFFFFFFF}}, "R10 cmp_value", cmp_value[31:0], 32'hFFFFFFFF);
    rd(0, 0, 4'd2, 32'h32, "R10 mask");
    rd(0, 0, 4'd5, 32'h80000000, "R10 route");
    rd(0, 0, 4'd8, 32'hFFFFFFFF, "R10 cmp");
    rd(0, 0, 4'd1, 32'h0, "R10 pend");
    rd(0, 0, 4'd6, 32'h0, "R10 other");
    rd(0, 0, 4'd0, 32'h0, "R10 ctrl");
    // R11 idle read gives zero
    @(negedge clk); bus_rd = 0; bus_reg = 4'd8;
    #1 check(bus_rdata === 0, "R11 idle", bus_rdata, 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].win, VECS[i].proc, VECS[i].rg, VECS[i].d);
      else rd(VECS[i].win, VECS[i].proc, VECS[i].rg, VECS[i].exp,
              $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    check(cmp_value[2*32 +: 32] === 32'h1234, "R7 cmp_value p2", cmp_value[2*32 +: 32], 32'h1234);

    // p1: route line 3 enabled, mask 0x32
    pulse(1);
    rd(0, 1, 4'd1, 32'h2, "R5 pend set");
    check(cpu_irq === (24'd1 << (1*NL+3)), "R6 line raised", 32'(cpu_irq), 32'(24'd1 << 9));
    wr(0, 1, 4'd4, 32'h2);
    #1 check(cpu_irq === '0, "R6 masked", 32'(cpu_irq), 0);
    rd(0, 1, 4'd1, 32'h2, "R6 pend kept while masked");
    wr(0, 1, 4'd3, 32'h2);
    #1 check(cpu_irq === (24'd1 << 9), "R6 unmasked", 32'(cpu_irq), 32'(24'd1 << 9));
    wr(0, 1, 4'd8, 32'h55);
    #1 check(cpu_irq === '0, "R7 irq cleared", 32'(cpu_irq), 0);
    rd(0, 1, 4'd1, 32'h0, "R7 pend cleared");
    // R7 write wins over simultaneous hit
    @(negedge clk);
    bus_wr = 1; bus_win = 0; bus_proc = 1; bus_reg = 4'd8; bus_wdata = 32'h66; cmp_hit[1] = 1;
    @(negedge clk);
    bus_wr = 0; cmp_hit[1] = 0;
    rd(0, 1, 4'd1, 32'h0, "R7 write beats hit");
    // p3 mask bit1 clear: pending but no line
    pulse(3);
    rd(0, 3, 4'd1, 32'h2, "R5 pend p3");
    check(cpu_irq === '0, "R6 p3 masked", 32'(cpu_irq), 0);
    // routing disabled on p1
    wr(0, 1, 4'd5, 32'h00000003);
    pulse(1);
    rd(0, 1, 4'd1, 32'h2, "R5 pend p1");
    check(cpu_irq === '0, "R6 route off", 32'(cpu_irq), 0);
    // re-enable on line 0 of p1
    wr(0, 1, 4'd5, 32'h80000000);
    #1 check(cpu_irq === (24'd1 << 6), "R6 line 0", 32'(cpu_irq), 32'(24'd1 << 6));
    // R11 write to unused index leaves state
    wr(0, 1, 4'd13, 32'hFFFFFFFF);
    rd(0, 1, 4'd2, 32'h32, "R11 unused write");

    finish_up();
  end
endmodule